// File: doc/BRIEF.md
# Host interrupt status controller

This block gathers single-cycle event pulses from the device side of a storage controller into a host-visible status register. The host clears a status bit by writing 1 to it. A mask register with the same bit layout blocks selected events from reaching the host, and a global enable bit in a control register gates the whole interrupt path. A control write can also soft-reset the block.

Alongside the level interrupt, the block sends one message-signalled interrupt code per event. Each code is a fixed number that does not follow the status bit position. When several events are waiting, the codes leave one per cycle, lowest status bit first. Every event is delivered once, and only while it is unmasked and the global enable is set.

The host reaches the block through a flat register port: an address, write data, a write strobe, and read data that is decoded combinationally.

Top module: `host_irq_ctrl`

## Requirements
- R1: After reset the status reads 0, the mask reads 0xFFFFFFFF, the control register reads 0, irq_o is low and msi_valid_o is low.
- R2: Status is read at address 0x520. An event pulse on evt_i[n] sets status bit n for the sources at bits 0-2 and 5-10. Bits 3 and 4 and bits 11-31 always read 0, and pulses on evt_i[3] or evt_i[4] are ignored.
- R3: Writing the status address clears every bit written as 1 and leaves bits written as 0 unchanged. If an event arrives in the same cycle as a clear of its bit, the bit stays set.
- R4: The mask register at address 0x528 holds all 32 written bits and reads them back. A mask bit of 1 keeps the matching status bit from driving irq_o or producing a message.
- R5: Control is at address 0x500, and bit 7 is the global enable. irq_o is high exactly when the enable is set and some status bit has its mask bit at 0.
- R6: The message codes are fixed per source: bit 0 gives 4, bit 1 gives 5, bit 2 gives 6, bits 5, 6, 7 and 8 give 9, 10, 11 and 12, bit 9 gives error code 0, and bit 10 gives error code 1.
- R7: Each event leaves a pending message. In each cycle in which the enable is set, the lowest pending unmasked bit is shown on msi_valid_o/msi_code_o for that one cycle and is then retired. A message that is masked or arrives while the enable is off waits. Clearing the status bit drops its pending message.
- R8: A control write with bit 1 set clears the status, all pending messages and the enable bit, and sets the mask to all ones. Bit 1 of control reads 0.
- R9: A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | Register address |
| wdata_i | input | 32 | Write data |
| wr_i | input | 1 | Write strobe |
| rdata_o | output | 32 | Read data for addr_i |
| evt_i | input | 11 | Event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt to the host |
| msi_valid_o | output | 1 | A message code is issued this cycle |
| msi_code_o | output | 4 | Message code |

## Verification
The bench builds the block with the default ADDR_W of 12. This gives the full register offsets, so an address that is only partly decoded is caught by the unmapped-address read. The source count and code width come from the package and are fixed by the layout, so every source bit and every code value is driven and compared. Batches of simultaneous events check the ascending issue order with one message per cycle. The bench also covers a clear that coincides with an event, pending messages that wait behind the mask or the enable, and a soft reset that arrives with events pending.

// File: rtl/hirq_pkg.sv
package hirq_pkg;
  localparam int unsigned NUM_SRC = 11;
  localparam int unsigned CODE_W  = 4;
  localparam int unsigned DATA_W  = 32;

  localparam logic [NUM_SRC-1:0] SRC_VALID = 11'h7E7;  // bits 3,4 reserved

  localparam logic [11:0] OFS_CTRL = 12'h500;
  localparam logic [11:0] OFS_STAT = 12'h520;
  localparam logic [11:0] OFS_MASK = 12'h528;

  localparam int unsigned CTRL_EN_BIT   = 7;
  localparam int unsigned CTRL_SRST_BIT = 1;

  function automatic logic [CODE_W-1:0] src_code(input int unsigned idx);
    case (idx)
      0:       src_code = 4'd4;
      1:       src_code = 4'd5;
      2:       src_code = 4'd6;
      5:       src_code = 4'd9;
      6:       src_code = 4'd10;
      7:       src_code = 4'd11;
      8:       src_code = 4'd12;
      9:       src_code = 4'd0;
      10:      src_code = 4'd1;
      default: src_code = 4'd0;
    endcase
  endfunction
endpackage

// File: rtl/hirq_regs.sv
module hirq_regs
  import hirq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_ctrl_i,
  input  logic              wr_mask_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              en_o,
  output logic [DATA_W-1:0] mask_o,
  output logic              srst_o
);
  logic              en_q;
  logic [DATA_W-1:0] mask_q;

  assign srst_o = wr_ctrl_i & wdata_i[CTRL_SRST_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else if (srst_o) begin
      en_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (wr_ctrl_i) en_q   <= wdata_i[CTRL_EN_BIT];
      if (wr_mask_i) mask_q <= wdata_i;
    end
  end

  assign en_o   = en_q;
  assign mask_o = mask_q;

  assert_srst_mask_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_o |=> (mask_q == '1) && !en_q);
endmodule

// File: rtl/hirq_status.sv
module hirq_status
  import hirq_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic [NUM_SRC-1:0] clr_i,
  input  logic [NUM_SRC-1:0] issue_i,
  input  logic               srst_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] pend_o
);
  logic [NUM_SRC-1:0] evt_v, status_q, pend_q;

  assign evt_v = evt_i & SRC_VALID;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      pend_q   <= '0;
    end else if (srst_i) begin
      status_q <= '0;
      pend_q   <= '0;
    end else begin
      // a new event beats a same-cycle clear
      status_q <= (status_q & ~clr_i) | evt_v;
      pend_q   <= (pend_q & ~clr_i & ~issue_i) | evt_v;
    end
  end

  assign status_o = status_q;
  assign pend_o   = pend_q;

  assert_reserved_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_q & ~SRC_VALID) == '0) && ((pend_q & ~SRC_VALID) == '0));

  assert_event_wins_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|evt_v) && !srst_i) |=> ((status_q & $past(evt_v)) == $past(evt_v)));

  assert_pend_has_status_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & ~status_q) == '0);
endmodule

// File: rtl/hirq_msi_arb.sv
module hirq_msi_arb
  import hirq_pkg::*;
(
  input  logic [NUM_SRC-1:0] pend_i,
  input  logic [NUM_SRC-1:0] mask_i,
  input  logic               en_i,
  output logic [NUM_SRC-1:0] issue_o,
  output logic               valid_o,
  output logic [CODE_W-1:0]  code_o
);
  logic [NUM_SRC-1:0] elig;
  logic               found;

  assign elig = en_i ? (pend_i & ~mask_i) : '0;

  always_comb begin
    issue_o = '0;
    code_o  = '0;
    found   = 1'b0;
    for (int unsigned i = 0; i < NUM_SRC; i++) begin
      if (elig[i] && !found) begin
        found      = 1'b1;
        issue_o[i] = 1'b1;
        code_o     = src_code(i);
      end
    end
  end

  assign valid_o = found;
endmodule

// File: rtl/host_irq_ctrl.sv
module host_irq_ctrl
  import hirq_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [31:0]        wdata_i,
  input  logic               wr_i,
  output logic [31:0]        rdata_o,
  input  logic [NUM_SRC-1:0] evt_i,
  output logic               irq_o,
  output logic               msi_valid_o,
  output logic [CODE_W-1:0]  msi_code_o
);
  logic hit_ctrl, hit_stat, hit_mask;
  logic en, srst;
  logic [DATA_W-1:0]  mask;
  logic [NUM_SRC-1:0] status, pend, issue, clr;

  assign hit_ctrl = (addr_i == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr_i == ADDR_W'(OFS_STAT));
  assign hit_mask = (addr_i == ADDR_W'(OFS_MASK));

  assign clr = (wr_i && hit_stat) ? wdata_i[NUM_SRC-1:0] : '0;

  hirq_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_ctrl_i (wr_i & hit_ctrl),
    .wr_mask_i (wr_i & hit_mask),
    .wdata_i   (wdata_i),
    .en_o      (en),
    .mask_o    (mask),
    .srst_o    (srst)
  );

  hirq_status u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .evt_i    (evt_i),
    .clr_i    (clr),
    .issue_i  (issue),
    .srst_i   (srst),
    .status_o (status),
    .pend_o   (pend)
  );

  hirq_msi_arb u_arb (
    .pend_i  (pend),
    .mask_i  (mask[NUM_SRC-1:0]),
    .en_i    (en),
    .issue_o (issue),
    .valid_o (msi_valid_o),
    .code_o  (msi_code_o)
  );

  assign irq_o = en & (|(status & ~mask[NUM_SRC-1:0]));

  always_comb begin
    rdata_o = '0;
    if (hit_ctrl)      rdata_o[CTRL_EN_BIT] = en;
    else if (hit_stat) rdata_o[NUM_SRC-1:0] = status;
    else if (hit_mask) rdata_o = mask;
  end

  assert_msi_onehot_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(issue) && (msi_valid_o == (issue != '0)));

  assert_msi_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msi_valid_o |-> en && ((issue & pend & ~mask[NUM_SRC-1:0]) != '0));

  assert_msi_retire_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msi_valid_o && !((issue & evt_i) != '0)) |=> ((pend & $past(issue)) == '0));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> en && (status != '0));

  assert_srst_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst |=> (status == '0) && (pend == '0) && !irq_o && !msi_valid_o);
endmodule

// File: tb/host_irq_ctrl_tb.sv
module host_irq_ctrl_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic        wr_i = 1'b0;
  logic [31:0] rdata_o;
  logic [10:0] evt_i = '0;
  logic        irq_o, msi_valid_o;
  logic [3:0]  msi_code_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  localparam logic [11:0] A_CTRL = 12'h500, A_STAT = 12'h520, A_MASK = 12'h528;

  // {wr, evt[10:0], wdata[31:0], expected status[31:0]}
  localparam logic [75:0] VECS [0:7] = '{
    {1'b0, 11'h001, 32'h0000_0000, 32'h0000_0001},  // R2
    {1'b0, 11'h018, 32'h0000_0000, 32'h0000_0001},  // R2 reserved ignored
    {1'b0, 11'h7E6, 32'h0000_0000, 32'h0000_07E7},  // R2
    {1'b1, 11'h000, 32'h0000_00F0, 32'h0000_0707},  // R3 clear
    {1'b1, 11'h002, 32'h0000_0003, 32'h0000_0706},  // R3 event wins
    {1'b1, 11'h000, 32'hFFFF_FFFF, 32'h0000_0000},  // R3
    {1'b0, 11'h400, 32'h0000_0000, 32'h0000_0400},  // R2
    {1'b1, 11'h000, 32'h0000_0000, 32'h0000_0400}   // R3 write 0 keeps
  };

  host_irq_ctrl u_dut (
    .clk_i, .rst_ni, .addr_i, .wdata_i, .wr_i, .rdata_o,
    .evt_i, .irq_o, .msi_valid_o, .msi_code_o
  );

  always #5 clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    addr_i = a; wdata_i = d; wr_i = 1'b1;
    @(negedge clk_i);
    wr_i = 1'b0; wdata_i = '0;
    #1;
  endtask

  task automatic reg_rd(input logic [11:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic pulse(input logic [10:0] e);
    @(negedge clk_i);
    evt_i = e;
    @(negedge clk_i);
    evt_i = '0;
    #1;
  endtask

  task automatic chk_msi(input string req, input logic v, input logic [3:0] c);
    chk(req, {31'b0, msi_valid_o}, {31'b0, v});
    if (v) chk(req, {28'b0, msi_code_o}, {28'b0, c});
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    logic [31:0] d;
    logic [3:0] codes_a [3] = '{4'd5, 4'd10, 4'd0};
    logic [3:0] codes_b [6] = '{4'd4, 4'd6, 4'd9, 4'd11, 4'd12, 4'd1};

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1 reset state
    reg_rd(A_STAT, d); chk("R1 status", d, 32'h0);
    reg_rd(A_MASK, d); chk("R1 mask", d, 32'hFFFF_FFFF);
    reg_rd(A_CTRL, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);
    chk("R1 msi", {31'b0, msi_valid_o}, 32'h0);

    // R2/R3 vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk_i);
      addr_i  = A_STAT;
      wr_i    = VECS[i][75];
      evt_i   = VECS[i][74:64];
      wdata_i = VECS[i][63:32];
      @(negedge clk_i);
      wr_i = 1'b0; evt_i = '0; wdata_i = '0;
      #1;
      chk($sformatf("R2/R3 vec%0d", i), rdata_o, VECS[i][31:0]);
    end

    // R9 unmapped address
    reg_rd(12'h530, d); chk("R9 unmapped", d, 32'h0);

    // R4 mask readback, R5 gating
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_wr(A_MASK, 32'hA5A5_0000);
    reg_rd(A_MASK, d); chk("R4 mask rw", d, 32'hA5A5_0000);
    reg_wr(A_MASK, 32'h0);
    reg_wr(A_CTRL, 32'h80);
    reg_rd(A_CTRL, d); chk("R5 ctrl", d, 32'h80);
    chk("R5 irq idle", {31'b0, irq_o}, 32'h0);

    // R6/R7 ordering
    pulse(11'h242);
    chk("R5 irq set", {31'b0, irq_o}, 32'h1);
    for (int i = 0; i < 3; i++) begin
      chk_msi("R6/R7 batch a", 1'b1, codes_a[i]);
      @(negedge clk_i); #1;
    end
    chk_msi("R7 batch a done", 1'b0, 4'd0);
    pulse(11'h5A5);
    for (int i = 0; i < 6; i++) begin
      chk_msi("R6/R7 batch b", 1'b1, codes_b[i]);
      @(negedge clk_i); #1;
    end
    chk_msi("R7 batch b done", 1'b0, 4'd0);
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    chk("R3 irq cleared", {31'b0, irq_o}, 32'h0);

    // R4 masked event waits
    reg_wr(A_MASK, 32'h1);
    pulse(11'h001);
    chk("R4 masked irq", {31'b0, irq_o}, 32'h0);
    chk_msi("R4 masked msi", 1'b0, 4'd0);
    reg_rd(A_STAT, d); chk("R4 status still set", d, 32'h1);
    reg_wr(A_MASK, 32'h0);
    chk_msi("R7 unmask issues", 1'b1, 4'd4);
    chk("R4 unmasked irq", {31'b0, irq_o}, 32'h1);
    @(negedge clk_i); #1;
    chk_msi("R7 issued once", 1'b0, 4'd0);

    // R5/R7 enable off
    reg_wr(A_CTRL, 32'h0);
    chk("R5 disabled irq", {31'b0, irq_o}, 32'h0);
    pulse(11'h004);
    chk_msi("R7 disabled waits", 1'b0, 4'd0);
    reg_wr(A_CTRL, 32'h80);
    chk_msi("R7 enable issues", 1'b1, 4'd6);
    @(negedge clk_i); #1;
    chk_msi("R7 enable once", 1'b0, 4'd0);

    // R7 clear drops pending
    reg_wr(A_CTRL, 32'h0);
    pulse(11'h020);
    reg_wr(A_STAT, 32'h20);
    reg_wr(A_CTRL, 32'h80);
    chk_msi("R7 cleared drop", 1'b0, 4'd0);

    // R8 soft reset
    pulse(11'h003);
    reg_wr(A_MASK, 32'h55);
    reg_wr(A_CTRL, 32'h82);
    reg_rd(A_STAT, d); chk("R8 status", d, 32'h0);
    reg_rd(A_MASK, d); chk("R8 mask", d, 32'hFFFF_FFFF);
    reg_rd(A_CTRL, d); chk("R8 ctrl", d, 32'h0);
    chk("R8 irq", {31'b0, irq_o}, 32'h0);
    reg_wr(A_MASK, 32'h0);
    reg_wr(A_CTRL, 32'h80);
    chk_msi("R8 pending gone", 1'b0, 4'd0);

    done = 1'b1;
    finish_run();
  end
endmodule